// File: doc/BRIEF.md
# Response Ring Writer with Interrupt Count

This block takes 64-bit responses arriving on a valid/ready stream and stores each one into a circular response buffer in memory through a simple write port. Before every store it advances its write pointer, so the pointer always names the newest entry. Software starts its own read index at zero and advances it before each read. Software can reset the pointer to zero through a register write.

A counter tracks stored responses against a programmable threshold. When the count reaches the threshold, an interrupt status flag is set and the counter restarts. Software normally programs the threshold to half the ring size. The block does not know software's read position. It counts the stores made since software last acknowledged the interrupt. When a store would overwrite an entry that software has not been told about, an overrun bit is set.

The ring size is picked from a capability set, with codes 0, 1 and 2 giving 2, 16 and 256 entries. A control register enables stores (the run bit) and gates the interrupt output.

Top module: `resp_ring_writer`

## Requirements
- R1: After reset, the following all read as zero: run, interrupt enable, threshold, write pointer, interrupt flag, overrun bit and `irq`. The size-select field holds the largest code whose capability bit is set.
- R2: `rsp_ready` equals the run bit (register 0, bit 0). While run is clear, no memory write occurs and the write pointer does not move.
- R3: Each accepted response first moves the write pointer to (pointer + 1) modulo the ring size. The entry is then written at that new index, and register 2 bits 7:0 read back that index.
- R4: The stored 64-bit word carries the response word in bits 31:0 and the extended word in bits 63:32, unchanged. This includes the unsolicited flag at extended-word bit 4.
- R5: Size-select field (register 1, bits 1:0): code 0 gives 2 entries, code 1 gives 16 and code 2 gives 256. A write with code 3, or with a code whose capability bit (register 1, bits 6:4, bit 4 for code 0) is clear, leaves the field unchanged.
- R6: Writing 1 to register 2 bit 15 sets the write pointer to zero. It also clears the stored-response counter and the pending count.
- R7: With threshold T > 0 (register 3), the store that brings the counter to T sets the interrupt flag (register 4, bit 0) in the same clock edge, and the counter returns to zero.
- R8: With threshold 0, the interrupt flag is never set by stores.
- R9: `irq` equals the interrupt flag ANDed with the interrupt enable (register 0, bit 1). Writing 1 to register 4 bit 0 clears the flag, and writing 0 leaves it unchanged.
- R10: A store made when the pending count already equals the ring size sets the overrun bit (register 4, bit 1). The pending count is the number of stores since the flag was last cleared or the pointer reset. Writing 1 to register 4 bit 1 clears the overrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 size, 2 pointer, 3 threshold, 4 status) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| rsp_valid | input | 1 | Response available |
| rsp_ready | output | 1 | Block accepts a response |
| rsp_word | input | 32 | Response word |
| rsp_ext | input | 32 | Extended word (bit 4 = unsolicited) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 8 | Ring entry index written |
| mem_wdata | output | 64 | Entry written to memory |
| irq | output | 1 | Response interrupt |

## Verification
If the write pointer is corrupted, it shows on `mem_addr` at the very next store and in the pointer register right after that store's edge. An error in modulo wrapping appears first on the store after the last index of the smallest ring. If the threshold counter is off by one, the flag rises one store early or late, so the flag is checked after every single store across each ring size and several thresholds. If the pending count is wrong, the overrun bit shows it on the first store beyond the ring size.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int PTR_W     = 8;
    localparam int REG_AW    = 3;
    localparam int REG_DW    = 16;
    localparam int CNT_W     = PTR_W + 1;
    localparam int WCLR_BIT  = 15;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL   = 3'd0,
        RA_SIZE   = 3'd1,
        RA_WPTR   = 3'd2,
        RA_THRESH = 3'd3,
        RA_STATUS = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [31:0] ext;
        logic [31:0] word;
    } entry_t;

    function automatic logic [CNT_W-1:0] ring_entries(input logic [1:0] sel);
        case (sel)
            2'd0:    return CNT_W'(2);
            2'd1:    return CNT_W'(16);
            default: return CNT_W'(256);
        endcase
    endfunction

    function automatic logic [1:0] largest_sel(input logic [2:0] cap);
        if (cap[2])      return 2'd2;
        else if (cap[1]) return 2'd1;
        else             return 2'd0;
    endfunction
endpackage

// File: rtl/rr_cfg.sv
module rr_cfg
    import rr_pkg::*;
#(
    parameter logic [2:0] CAP = 3'b111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic              run,
    output logic              ien,
    output logic [1:0]        sel,
    output logic [REG_DW-1:0] thresh
);
    logic sel_ok;
    assign sel_ok = (wdata[1:0] != 2'd3) && CAP[wdata[1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            ien    <= 1'b0;
            sel    <= largest_sel(CAP);
            thresh <= '0;
        end else if (we) begin
            case (addr)
                RA_CTRL:   begin run <= wdata[0]; ien <= wdata[1]; end
                RA_SIZE:   if (sel_ok) sel <= wdata[1:0];
                RA_THRESH: thresh <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/rr_ptr.sv
module rr_ptr
    import rr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             store,
    input  logic             clr,
    input  logic [1:0]       sel,
    output logic [PTR_W-1:0] wp_q,
    output logic [PTR_W-1:0] wp_next,
    output logic [PTR_W-1:0] mask
);
    logic [CNT_W-1:0] n_ent;
    assign n_ent   = ring_entries(sel) - CNT_W'(1);
    assign mask    = n_ent[PTR_W-1:0];
    assign wp_next = (wp_q + PTR_W'(1)) & mask;

    always_ff @(posedge clk) begin
        if (rst || clr) wp_q <= '0;
        else if (store) wp_q <= wp_next;
    end
endmodule

// File: rtl/rr_irq.sv
module rr_irq
    import rr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              store,
    input  logic [REG_DW-1:0] thresh,
    input  logic [CNT_W-1:0]  entries,
    input  logic              flag_clr,
    input  logic              ovr_clr,
    input  logic              wp_clr,
    output logic              flag,
    output logic              ovr
);
    logic [REG_DW-1:0] cnt;
    logic [REG_DW-1:0] cnt_inc;
    logic [CNT_W-1:0]  pend;
    logic              hit;

    assign cnt_inc = cnt + REG_DW'(1);
    assign hit     = store && (thresh != '0) && (cnt_inc >= thresh);

    always_ff @(posedge clk) begin
        if (rst || wp_clr)  cnt <= '0;
        else if (hit)       cnt <= '0;
        else if (store)     cnt <= cnt_inc;
    end

    always_ff @(posedge clk) begin
        if (rst)                 flag <= 1'b0;
        else if (hit)            flag <= 1'b1;
        else if (flag_clr)       flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || wp_clr || flag_clr) pend <= '0;
        else if (store && pend < entries) pend <= pend + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)                              ovr <= 1'b0;
        else if (store && pend >= entries && !flag_clr && !wp_clr) ovr <= 1'b1;
        else if (ovr_clr)                     ovr <= 1'b0;
    end
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
    import rr_pkg::*;
#(
    parameter logic [2:0] CAP = 3'b111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [31:0]       rsp_word,
    input  logic [31:0]       rsp_ext,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [63:0]       mem_wdata,
    output logic              irq
);
    logic              run, irq_en, irq_flag, ovr, store;
    logic              wp_clr, flag_clr, ovr_clr;
    logic [1:0]        sel;
    logic [REG_DW-1:0] thresh;
    logic [PTR_W-1:0]  wp_q, wp_next, ring_mask;
    entry_t            ent;

    assign wp_clr   = reg_we && (reg_addr == RA_WPTR)   && reg_wdata[WCLR_BIT];
    assign flag_clr = reg_we && (reg_addr == RA_STATUS) && reg_wdata[0];
    assign ovr_clr  = reg_we && (reg_addr == RA_STATUS) && reg_wdata[1];

    rr_cfg #(.CAP(CAP)) u_cfg (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .run(run), .ien(irq_en), .sel(sel), .thresh(thresh)
    );

    assign rsp_ready = run;
    assign store     = rsp_valid && run;

    rr_ptr u_ptr (
        .clk(clk), .rst(rst), .store(store), .clr(wp_clr), .sel(sel),
        .wp_q(wp_q), .wp_next(wp_next), .mask(ring_mask)
    );

    rr_irq u_irq (
        .clk(clk), .rst(rst), .store(store), .thresh(thresh),
        .entries(ring_entries(sel)), .flag_clr(flag_clr), .ovr_clr(ovr_clr),
        .wp_clr(wp_clr), .flag(irq_flag), .ovr(ovr)
    );

    assign ent.word  = rsp_word;
    assign ent.ext   = rsp_ext;
    assign mem_we    = store;
    assign mem_addr  = wp_next;
    assign mem_wdata = ent;
    assign irq       = irq_flag && irq_en;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:   reg_rdata = {14'd0, irq_en, run};
            RA_SIZE:   reg_rdata = {9'd0, CAP, 2'd0, sel};
            RA_WPTR:   reg_rdata = {8'd0, wp_q};
            RA_THRESH: reg_rdata = thresh;
            RA_STATUS: reg_rdata = {14'd0, ovr, irq_flag};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/resp_ring_writer_chk.sv
module resp_ring_writer_chk
    import rr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rsp_ready,
    input logic             mem_we,
    input logic [PTR_W-1:0] mem_addr,
    input logic [PTR_W-1:0] wp,
    input logic [PTR_W-1:0] mask,
    input logic             ien,
    input logic             irq,
    input logic             flag,
    input logic             wp_clr
);
    AST_NO_STORE_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !rsp_ready |-> !mem_we); // R2
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !wp_clr) |=> (wp == $past(mem_addr))); // R3
    AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_addr & ~mask) == '0)); // R5
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wp_clr |=> (wp == '0)); // R6
    AST_FLAG_FROM_STORE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(mem_we)); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien && flag)); // R9
endmodule

bind resp_ring_writer resp_ring_writer_chk u_chk (
    .clk(clk), .rst(rst), .rsp_ready(rsp_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .wp(wp_q), .mask(ring_mask), .ien(irq_en),
    .irq(irq), .flag(irq_flag), .wp_clr(wp_clr)
);

// File: tb/test_resp_ring_writer.sv
module test_resp_ring_writer;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_word = '0;
    logic [31:0] rsp_ext = '0;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [63:0] mem_wdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int wp_m, cnt_m, pend_m, thr_m, ent_m;
    bit flag_m, ovr_m;

    always #(PERIOD/2) clk = ~clk;

    resp_ring_writer i_resp_ring_writer (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_word(rsp_word), .rsp_ext(rsp_ext),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        reg_addr = 3'(a);
        #1 v = reg_rdata;
    endtask

    task automatic clear_state();
        wr(2, 16'h8000);
        wr(4, 3);
        wp_m = 0; cnt_m = 0; pend_m = 0; flag_m = 0; ovr_m = 0;
    endtask

    task automatic push(input int i);
        logic [15:0] v;
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_word  = 32'hA000_0000 + 32'(i);
        rsp_ext   = {16'(i), 11'd0, 1'(i % 2), 4'h3};
        wp_m = (wp_m + 1) % ent_m;
        #1;
        chk("R3 mem_addr", 64'(mem_addr), 64'(wp_m));
        chk("R4 entry", mem_wdata, {rsp_ext, rsp_word});
        cnt_m++;
        if (thr_m != 0 && cnt_m >= thr_m) begin flag_m = 1; cnt_m = 0; end
        if (pend_m >= ent_m) ovr_m = 1; else pend_m++;
        @(negedge clk);
        rsp_valid = 1'b0;
        rd(2, v);
        chk("R3 wptr", 64'(v), 64'(wp_m));
        rd(4, v);
        chk("R7 R8 R10 status", 64'(v[1:0]), 64'({ovr_m, flag_m}));
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        rd(0, v); chk("R1 ctrl", 64'(v), 64'h0);
        rd(1, v); chk("R1 size", 64'(v), 64'h0072);
        rd(2, v); chk("R1 wptr", 64'(v), 64'h0);
        rd(3, v); chk("R1 thresh", 64'(v), 64'h0);
        rd(4, v); chk("R1 status", 64'(v), 64'h0);
        chk("R1 irq", 64'(irq), 64'h0);

        // R2 stopped: no store, pointer stays
        @(negedge clk);
        rsp_valid = 1'b1;
        #1;
        chk("R2 ready", 64'(rsp_ready), 64'h0);
        chk("R2 no write", 64'(mem_we), 64'h0);
        @(negedge clk);
        rsp_valid = 1'b0;
        rd(2, v); chk("R2 wptr still", 64'(v), 64'h0);

        // R5 invalid code ignored
        wr(1, 3);
        rd(1, v); chk("R5 code3 ignored", 64'(v[1:0]), 64'h2);

        wr(0, 3);
        #1 chk("R2 ready on run", 64'(rsp_ready), 64'h1);

        // sweep sizes and thresholds (R3 R4 R5 R7 R9)
        for (int s = 0; s < 3; s++) begin
            wr(1, s);
            rd(1, v); chk("R5 size sel", 64'(v[1:0]), 64'(s));
            ent_m = (s == 0) ? 2 : (s == 1) ? 16 : 256;
            for (int t = 0; t < 3; t++) begin
                thr_m = (t == 0) ? 1 : (t == 1) ? ent_m / 2 : ent_m;
                wr(3, thr_m);
                clear_state();
                for (int i = 0; i < 2 * ent_m + 3; i++) begin
                    push(i);
                    if (flag_m) begin
                        chk("R9 irq on", 64'(irq), 64'h1);
                        wr(4, 1);
                        flag_m = 0; pend_m = 0;
                        rd(4, v); chk("R9 flag cleared", 64'(v[0]), 64'h0);
                    end
                end
            end
        end

        // R6 pointer reset
        wr(1, 1); ent_m = 16;
        clear_state(); thr_m = 0; wr(3, 0);
        push(1); push(2); push(3);
        wr(2, 16'h8000); wp_m = 0; cnt_m = 0; pend_m = 0;
        rd(2, v); chk("R6 wptr zero", 64'(v), 64'h0);
        push(4);

        // R8 and R10: threshold zero, ring of 2, overrun on third store
        wr(1, 0); ent_m = 2;
        clear_state(); thr_m = 0; wr(3, 0);
        push(10); push(11);
        push(12);
        chk("R10 overrun set", 64'(ovr_m), 64'h1);
        chk("R8 no irq", 64'(irq), 64'h0);
        wr(4, 2); ovr_m = 0;
        rd(4, v); chk("R10 overrun cleared", 64'(v), 64'h0);

        // R9: enable gates irq; writing 0 leaves flag
        thr_m = 1; wr(3, 1); clear_state();
        wr(0, 1);
        push(20);
        chk("R9 irq gated off", 64'(irq), 64'h0);
        wr(4, 0);
        rd(4, v); chk("R9 write0 keeps flag", 64'(v[0]), 64'h1);
        wr(0, 3);
        #1 chk("R9 irq enabled", 64'(irq), 64'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule